// File: doc/BRIEF.md
# Multi-length PRBS test pattern generator

This block produces a pseudo-random bit stream that replaces outgoing line data during diagnostics and production test. One 23-bit shift register serves all four sequence lengths; a two-bit select picks the feedback taps. An optional zero-run limiter keeps the line from seeing long runs of zeros. A framed mode leaves the framing bit positions to the framer.

The transmit path advances the generator with a per-bit enable. It uses the overwrite flag to choose between its own data and the pattern bit. Raising the start control, or changing the select, restarts the sequence from the all-ones state. A single-cycle inject pulse corrupts exactly one later pattern bit, so a far-end checker can be shown to detect errors.

Top module: `prbs_test_gen`

## Requirements
- R1: The generated bit obeys b(n) = b(n-L) xor b(n-T), where the history before a restart counts as all ones. The select encoding is 00: L=11, T=9; 01: L=15, T=14; 10: L=20, T=17; 11: L=23, T=18. So with select 00 the first nine bits after a restart are 0 and the tenth is 1.
- R2: A rising edge of `start` or any change of `pat_sel` restarts the sequence from all ones, effective for the bit presented in that same cycle. The generator state is never all zeros.
- R3: While `start` is low, `ovr` and `pat_bit` are both 0 and the sequence does not advance.
- R4: With `start` high and framed mode off, `ovr` is 1 on every cycle and each cycle with `bit_en` high consumes one sequence bit.
- R5: With framed mode on, a cycle with `frame_pos` high gives `ovr` = 0 and `pat_bit` = 0, and it consumes no sequence bit.
- R6: With `zcs_en` high, a bit that would follow 14 consecutive generated zeros is output as 1. The underlying sequence is not altered. With select 11 after a restart, the outputs are 14 zeros, a 1, three zeros and then a 1.
- R7: An `err_inj` pulse inverts exactly one output bit: the first consumed bit in the same cycle as the pulse or later. The bits that follow are unaffected.
- R8: With select 00 the sequence repeats every 2047 bits and contains 1024 ones per period.
- R9: A cycle with `bit_en` low consumes no sequence bit, and the same bit is presented again on the next cycle.
- R10: An active-low asynchronous reset leaves the generator at all ones with no error pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Consume one pattern bit this cycle |
| frame_pos | input | 1 | Current bit is a framing bit position |
| pat_sel | input | 2 | Sequence length select |
| zcs_en | input | 1 | Enable zero-run limiting |
| framed_en | input | 1 | Leave framing positions untouched |
| start | input | 1 | Run the generator and overwrite data |
| err_inj | input | 1 | Pulse to corrupt one following bit |
| pat_bit | output | 1 | Pattern bit for the current position |
| ovr | output | 1 | Replace line data with `pat_bit` |

## Verification
Directed restarts on the shortest and longest sequences check the exact opening run of zeros. With and without zero-run limiting, these runs tell the tap choice apart from the forcing rule. A full double period of the shortest sequence separates correct taps from any non-maximal polynomial through its repeat distance and its count of ones. Random mixes of bit enables, framing positions, select changes, start toggles and inject pulses are compared bit by bit against a reference model. These mixes expose stalls that advance when they should not, restarts that fire late, and error pulses that are lost or applied twice.

// File: rtl/prbs_test_gen.sv
module prbs_test_gen #(
  parameter int ZRUN = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_pos,
  input  logic [1:0] pat_sel,
  input  logic       zcs_en,
  input  logic       framed_en,
  input  logic       start,
  input  logic       err_inj,
  output logic       pat_bit,
  output logic       ovr
);
  localparam int W  = 23;
  localparam int ZW = $clog2(ZRUN + 1) + 1;

  logic [W-1:0]  lfsr, cur;
  logic [ZW-1:0] zcnt, zc_cur;
  logic          start_q, pend, reload, step, fb, zforce, gbit, flip;
  logic [1:0]    sel_q;

  assign reload = (start & ~start_q) | (pat_sel != sel_q);
  assign cur    = reload ? '1 : lfsr;
  assign zc_cur = reload ? '0 : zcnt;

  always_comb begin
    case (pat_sel)
      2'd0:    fb = cur[10] ^ cur[8];
      2'd1:    fb = cur[14] ^ cur[13];
      2'd2:    fb = cur[19] ^ cur[16];
      default: fb = cur[22] ^ cur[17];
    endcase
  end

  assign zforce  = zcs_en & (zc_cur == ZW'(ZRUN));
  assign gbit    = fb | zforce;
  assign flip    = err_inj | pend;
  assign ovr     = start & ~(framed_en & frame_pos);
  assign step    = ovr & bit_en;
  assign pat_bit = ovr & (gbit ^ flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr    <= '1;
      zcnt    <= '0;
      pend    <= 1'b0;
      start_q <= 1'b0;
      sel_q   <= 2'd0;
    end else begin
      start_q <= start;
      sel_q   <= pat_sel;
      if (step) begin
        lfsr <= {cur[W-2:0], fb};
        if (gbit)                        zcnt <= '0;
        else if (zc_cur == ZW'(ZRUN))    zcnt <= zc_cur;
        else                             zcnt <= zc_cur + 1'b1;
      end else if (reload) begin
        lfsr <= '1;
        zcnt <= '0;
      end
      if (step)         pend <= 1'b0;
      else if (err_inj) pend <= 1'b1;
    end
  end
endmodule

module prbs_test_gen_chk #(
  parameter int ZRUN = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bit_en,
  input logic        framed_en,
  input logic        frame_pos,
  input logic        zcs_en,
  input logic        ovr,
  input logic        pat_bit,
  input logic        reload,
  input logic        step,
  input logic        flip,
  input logic [22:0] lfsr
);
  int zrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zrun <= 0;
    else if (reload && !step) zrun <= 0;
    else if (step) begin
      if (!zcs_en || flip || pat_bit || reload) zrun <= 0;
      else zrun <= zrun + 1;
    end
  end

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> (!ovr && !pat_bit));

  p_framed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && framed_en && frame_pos && !reload) |=> $stable(lfsr));

  p_noadv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !reload) |=> $stable(lfsr));

  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_zcs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && zcs_en && !flip && !reload && zrun >= ZRUN) |-> pat_bit);
endmodule

bind prbs_test_gen prbs_test_gen_chk #(.ZRUN(ZRUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
  .framed_en(framed_en), .frame_pos(frame_pos), .zcs_en(zcs_en),
  .ovr(ovr), .pat_bit(pat_bit), .reload(reload), .step(step),
  .flip(flip), .lfsr(lfsr)
);

// File: tb/tb_prbs_test_gen.sv
`timescale 1ns/1ps
module tb_prbs_test_gen;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, frame_pos = 0, zcs_en = 0, framed_en = 0, start = 0, err_inj = 0;
  logic [1:0] pat_sel = 0;
  logic pat_bit, ovr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [22:0] mh;
  int mz;
  logic mp, mss, last_bit;
  logic [1:0] msq;
  logic seqbuf [0:4095];

  always #2.5 clk = ~clk;

  prbs_test_gen dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pos(frame_pos),
    .pat_sel(pat_sel), .zcs_en(zcs_en), .framed_en(framed_en), .start(start),
    .err_inj(err_inj), .pat_bit(pat_bit), .ovr(ovr));

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic tapbit(logic [22:0] c, logic [1:0] s);
    case (s)
      2'd0: return c[10] ^ c[8];
      2'd1: return c[14] ^ c[13];
      2'd2: return c[19] ^ c[16];
      default: return c[22] ^ c[17];
    endcase
  endfunction

  task automatic tick(string req);
    logic [22:0] c; int z; logic rl, f, g, fl, eo, st;
    #1;
    rl = (start && !mss) || (pat_sel != msq);
    c  = rl ? '1 : mh;
    z  = rl ? 0 : mz;
    f  = tapbit(c, pat_sel);
    g  = f | (zcs_en && z == 14);
    fl = err_inj | mp;
    eo = start & ~(framed_en & frame_pos);
    st = eo & bit_en;
    chk(req, {ovr, pat_bit}, {eo, eo & (g ^ fl)});
    last_bit = pat_bit;
    @(posedge clk);
    if (st) begin
      mh = {c[21:0], f};
      mz = g ? 0 : (z == 14 ? 14 : z + 1);
    end else if (rl) begin
      mh = '1; mz = 0;
    end
    mp = st ? 1'b0 : (err_inj ? 1'b1 : mp);
    mss = start; msq = pat_sel;
    @(negedge clk);
  endtask

  task automatic idle2;
    start = 0; bit_en = 0; err_inj = 0; framed_en = 0; zcs_en = 0;
    tick("R3"); tick("R3");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    mh = '1; mz = 0; mp = 0; mss = 0; msq = 0;
    @(negedge clk);
    #1 chk("R10", {ovr, pat_bit}, 2'b00);
    @(negedge clk);
    rst_n = 1;
    idle2();

    // R1: select 00 opening run
    pat_sel = 0; start = 1; bit_en = 1;
    for (int i = 0; i < 11; i++) begin
      tick("R1");
      chk("R1", {1'b0, last_bit}, {1'b0, (i >= 9) ? 1'b1 : 1'b0});
    end
    idle2();

    // R6: select 11 with and without zero-run limiting
    pat_sel = 3; tick("R2");
    start = 1; bit_en = 1; zcs_en = 1;
    for (int i = 0; i < 19; i++) begin
      tick("R6");
      chk("R6", {1'b0, last_bit}, {1'b0, (i == 14 || i == 18) ? 1'b1 : 1'b0});
    end
    idle2();
    start = 1; bit_en = 1;
    for (int i = 0; i < 19; i++) begin
      tick("R1");
      chk("R1", {1'b0, last_bit}, {1'b0, (i == 18) ? 1'b1 : 1'b0});
    end
    idle2();

    // R7 and R9: inject during a stalled cycle
    pat_sel = 0; tick("R2");
    start = 1; bit_en = 1;
    for (int i = 0; i < 3; i++) tick("R4");
    bit_en = 0; err_inj = 1; tick("R9");
    err_inj = 0; tick("R9");
    chk("R9", {1'b0, last_bit}, 2'b01);
    bit_en = 1; tick("R7");
    chk("R7", {1'b0, last_bit}, 2'b01);
    tick("R7");
    chk("R7", {1'b0, last_bit}, 2'b00);

    // R5: framed stall
    framed_en = 1; frame_pos = 1; tick("R5");
    chk("R5", {ovr, last_bit}, 2'b00);
    frame_pos = 0; tick("R5");
    chk("R5", {1'b0, last_bit}, 2'b00);
    framed_en = 0;
    idle2();

    // R8: period and balance of select 00
    pat_sel = 0; start = 1; bit_en = 1;
    for (int i = 0; i < 4094; i++) begin
      tick("R8");
      seqbuf[i] = last_bit;
    end
    begin
      int ones = 0, mism = 0;
      for (int i = 0; i < 2047; i++) begin
        ones += seqbuf[i];
        if (seqbuf[i] != seqbuf[i + 2047]) mism++;
      end
      chk("R8", {1'b0, ones == 1024}, 2'b01);
      chk("R8", {1'b0, mism == 0}, 2'b01);
    end
    idle2();

    // Random mix against the model
    for (int i = 0; i < 20000; i++) begin
      bit_en    = ($urandom % 4) != 0;
      frame_pos = ($urandom % 8) == 0;
      err_inj   = ($urandom % 40) == 0;
      if ($urandom % 300 == 0) pat_sel = 2'($urandom);
      if ($urandom % 500 == 0) start = ~start;
      if ($urandom % 700 == 0) framed_en = ~framed_en;
      if ($urandom % 900 == 0) zcs_en = ~zcs_en;
      tick(framed_en ? "R5" : "R4");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule